// File: doc/BRIEF.md
# Right-Justified Serial Audio Word Receiver

This block turns a three-wire serial audio stream into parallel samples. The three wires are a bit clock, a word clock and a data line. All of them are sampled by a faster system clock. Each wire passes through a two-stage synchronizer and an edge detector before any logic uses it. On every bit-clock rising edge the data bit moves into a shift register, most significant bit first. The word is right-justified, so only the newest bits count. When the word clock falls, the newest 24 bits are copied into a holding register. In short-word mode the newest 20 bits are copied instead and sign-extended to 24. The copy is made on the falling edge even if the bit clock has stopped at that point.

The holding register does not reach the output at once. The output takes the held word on the second bit-clock rising edge after the word-clock fall. A single-cycle valid strobe marks that update. A sticky framing-error flag is set if the word clock rises before the bit clock has completed its first rising edge of the new word. The system clock must run at least four times faster than the bit clock.

Top module: `rjs_audio_rx`

## Requirements
- R1: While `rst` is high, and on the cycle after it is sampled high, `sample_out` reads 0, `sample_valid_out` reads 0 and `frame_err_out` reads 0.
- R2: With `long_word_in` = 1, the 24 bits sampled on the last 24 bit-clock rising edges before the word-clock fall appear on `sample_out`. The first of those 24 bits becomes bit 23.
- R3: Any number of bits shifted in before those final bits is discarded. Examples are 0 to 8 extra bits, or a 32-bit frame.
- R4: With `long_word_in` = 0, only the last 20 bits count. Bit 19 of that word is copied into `sample_out[23:20]`. For example, 0x7FFFF gives 0x07FFFF and 0x80000 gives 0xF80000.
- R5: `sample_out` does not change on the first bit-clock rising edge after the word-clock fall. It takes the captured word only after the second such edge.
- R6: `sample_valid_out` is a one-cycle pulse, exactly one per delivered word, and `sample_out` changes only in a cycle where it is high.
- R7: The word is captured at the word-clock fall even if the bit clock is stopped. Bits shifted in after the fall, and any length of stopped clock, do not alter the delivered word.
- R8: If the word clock rises after a fall with no bit-clock rising edge in between, `frame_err_out` goes to 1. It stays at 1 until reset.
- R9: Frames that keep the word clock low through at least one bit-clock rising edge leave `frame_err_out` at 0.
- R10: The codes 0x7FFFFF, 0x000000, 0xFFFFFF and 0x800000 pass through unchanged in 24-bit mode. These are positive full scale, zero, one step below zero and negative full scale.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the bit-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| bit_clk_in | input | 1 | Serial bit clock, asynchronous |
| word_clk_in | input | 1 | Word clock; its falling edge ends a word |
| data_in | input | 1 | Serial data, MSB first, two's complement |
| long_word_in | input | 1 | 1 selects 24-bit words, 0 selects 20-bit words |
| sample_out | output | 24 | Last delivered sample |
| sample_valid_out | output | 1 | One-cycle strobe on each update of `sample_out` |
| frame_err_out | output | 1 | Sticky framing-error flag |

## Verification
Some properties are checked by assertions on every cycle:
- the reset values;
- that the valid strobe is a single-cycle pulse;
- that the output changes only under the strobe;
- that each strobe follows a detected bit-clock rise;
- that the error flag is sticky and is only raised just after a word-clock rise.

Other behaviour needs the bench's scenarios: which bits are kept, the discarding of leading bits, sign extension, the two-edge delay, and capture while the bit clock is stopped. These are checked by comparing `sample_out` against the value the bench built, at chosen points in the serial sequence.

// File: rtl/rjs_pkg.sv
package rjs_pkg;

  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } edge_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ARMED = 2'd1,
    PH_ONE   = 2'd2
  } phase_t;

  localparam int unsigned PIN_BCK  = 0;
  localparam int unsigned PIN_WCK  = 1;
  localparam int unsigned PIN_DAT  = 2;
  localparam int unsigned PIN_MODE = 3;
  localparam int unsigned PIN_CNT  = 4;

endpackage

// File: rtl/rjs_sync.sv
module rjs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pin,
  output rjs_pkg::edge_t ev
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  always_comb begin
    ev.level = chain_q[STAGES-1];
    ev.rise  = chain_q[STAGES-1] & ~prev_q;
    ev.fall  = ~chain_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/rjs_shift.sv
module rjs_shift #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] sreg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
    end else if (shift_en) begin
      sreg <= {sreg[WORD_W-2:0], bit_in};
    end
  end
endmodule

// File: rtl/rjs_xfer.sv
module rjs_xfer #(
  parameter int unsigned WORD_W  = 24,
  parameter int unsigned SHORT_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] sreg,
  input  logic              long_word,
  input  logic              capture,
  input  logic              bck_rise,
  output logic [WORD_W-1:0] sample,
  output logic              valid
);
  import rjs_pkg::*;

  localparam int unsigned EXT_W = WORD_W - SHORT_W;

  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] narrow_ext;
  phase_t            phase_q;

  assign narrow_ext = {{EXT_W{sreg[SHORT_W-1]}}, sreg[SHORT_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      sample  <= '0;
      valid   <= 1'b0;
      phase_q <= PH_IDLE;
    end else begin
      valid <= 1'b0;
      if (capture) begin
        hold_q  <= long_word ? sreg : narrow_ext;
        phase_q <= PH_ARMED;
      end else if (bck_rise) begin
        case (phase_q)
          PH_ARMED: phase_q <= PH_ONE;
          PH_ONE: begin
            sample  <= hold_q;
            valid   <= 1'b1;
            phase_q <= PH_IDLE;
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rjs_framer.sv
module rjs_framer (
  input  logic clk,
  input  logic rst,
  input  logic wck_fall,
  input  logic wck_rise,
  input  logic bck_rise,
  output logic err
);
  logic await_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      await_q <= 1'b0;
      err     <= 1'b0;
    end else begin
      if (wck_fall) begin
        await_q <= 1'b1;
      end else if (bck_rise) begin
        await_q <= 1'b0;
      end
      if (wck_rise && await_q) begin
        err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rjs_audio_rx.sv
module rjs_audio_rx #(
  parameter int unsigned WORD_W      = 24,
  parameter int unsigned SHORT_W     = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_clk_in,
  input  logic              word_clk_in,
  input  logic              data_in,
  input  logic              long_word_in,
  output logic [WORD_W-1:0] sample_out,
  output logic              sample_valid_out,
  output logic              frame_err_out
);
  import rjs_pkg::*;

  logic [PIN_CNT-1:0] pins;
  edge_t              ev [PIN_CNT];
  logic               bck_rise;
  logic               wck_rise;
  logic               wck_fall;
  logic [WORD_W-1:0]  sreg;

  assign pins[PIN_BCK]  = bit_clk_in;
  assign pins[PIN_WCK]  = word_clk_in;
  assign pins[PIN_DAT]  = data_in;
  assign pins[PIN_MODE] = long_word_in;

  for (genvar g = 0; g < PIN_CNT; g++) begin : g_sync
    rjs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .pin (pins[g]),
      .ev  (ev[g])
    );
  end

  assign bck_rise = ev[PIN_BCK].rise;
  assign wck_rise = ev[PIN_WCK].rise;
  assign wck_fall = ev[PIN_WCK].fall;

  rjs_shift #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (bck_rise),
    .bit_in   (ev[PIN_DAT].level),
    .sreg     (sreg)
  );

  rjs_xfer #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) u_xfer (
    .clk       (clk),
    .rst       (rst),
    .sreg      (sreg),
    .long_word (ev[PIN_MODE].level),
    .capture   (wck_fall),
    .bck_rise  (bck_rise),
    .sample    (sample_out),
    .valid     (sample_valid_out)
  );

  rjs_framer u_framer (
    .clk      (clk),
    .rst      (rst),
    .wck_fall (wck_fall),
    .wck_rise (wck_rise),
    .bck_rise (bck_rise),
    .err      (frame_err_out)
  );
endmodule

// File: rtl/rjs_audio_rx_chk.sv
module rjs_audio_rx_chk #(
  parameter int unsigned WORD_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] sample_out,
  input logic              sample_valid_out,
  input logic              frame_err_out,
  input logic              bck_rise,
  input logic              wck_rise
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (sample_out == '0 && !sample_valid_out && !frame_err_out));

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sample_valid_out |=> !sample_valid_out);

  // R6
  change_on_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sample_out) |-> sample_valid_out);

  // R5
  valid_after_bck_chk: assert property (@(posedge clk) disable iff (rst)
    sample_valid_out |-> $past(bck_rise));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    frame_err_out |=> frame_err_out);

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_err_out) |-> $past(wck_rise));
endmodule

bind rjs_audio_rx rjs_audio_rx_chk #(.WORD_W(WORD_W)) chk_i (
  .clk              (clk),
  .rst              (rst),
  .sample_out       (sample_out),
  .sample_valid_out (sample_valid_out),
  .frame_err_out    (frame_err_out),
  .bck_rise         (bck_rise),
  .wck_rise         (wck_rise)
);

// File: tb/rjs_audio_rx_tb.sv
module rjs_audio_rx_tb_top;
  localparam int unsigned W = 24;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bck = 1'b0;
  logic         wck = 1'b0;
  logic         dat = 1'b0;
  logic         long_w = 1'b1;
  logic [W-1:0] sample;
  logic         valid;
  logic         err;

  int n_cmp = 0;
  int n_bad = 0;
  int vcnt  = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  rjs_audio_rx dut_i (
    .clk              (clk),
    .rst              (rst),
    .bit_clk_in       (bck),
    .word_clk_in      (wck),
    .data_in          (dat),
    .long_word_in     (long_w),
    .sample_out       (sample),
    .sample_valid_out (valid),
    .frame_err_out    (err)
  );

  always @(posedge clk) if (!rst && valid) vcnt++;

  function automatic logic [W-1:0] expect_word(logic [W-1:0] v, bit lw);
    return lw ? v : {{4{v[19]}}, v[19:0]};
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bclk_cycle(bit d);
    dat = d;
    bck = 1'b0;
    repeat (4) @(negedge clk);
    bck = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_word(logic [W-1:0] v, bit lw, int nlead);
    long_w = lw;
    wck = 1'b1;
    for (int i = 0; i < nlead; i++) bclk_cycle(1'($urandom % 2));
    for (int i = (lw ? 23 : 19); i >= 0; i--) bclk_cycle(v[i]);
    bck = 1'b0;
    repeat (2) @(negedge clk);
    wck = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_word(logic [W-1:0] exp, string req);
    logic [W-1:0] s0;
    int v0;
    s0 = sample;
    v0 = vcnt;
    bclk_cycle(1'($urandom % 2));
    bck = 1'b0;
    repeat (4) @(negedge clk);
    check("R5", sample, s0);
    check("R5", 24'(vcnt), 24'(v0));
    bclk_cycle(1'($urandom % 2));
    bck = 1'b0;
    repeat (4) @(negedge clk);
    check(req, sample, exp);
    check("R6", 24'(vcnt), 24'(v0 + 1));
  endtask

  initial begin
    logic [W-1:0] v;
    bit lw;
    void'($urandom(32'd2718));
    repeat (5) @(negedge clk);
    check("R1", sample, '0);
    check("R1", {22'd0, valid, err}, '0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R2 / R10 directed codes, 24-bit
    send_word(24'h7FFFFF, 1'b1, 0); finish_word(24'h7FFFFF, "R10");
    send_word(24'h800000, 1'b1, 3); finish_word(24'h800000, "R10");
    send_word(24'hFFFFFF, 1'b1, 1); finish_word(24'hFFFFFF, "R10");
    send_word(24'h000000, 1'b1, 2); finish_word(24'h000000, "R10");
    send_word(24'hA5C3E1, 1'b1, 0); finish_word(24'hA5C3E1, "R2");
    // R3 32-bit frame
    send_word(24'h123456, 1'b1, 8); finish_word(24'h123456, "R3");
    // R4 short words
    send_word(24'h07FFFF, 1'b0, 4); finish_word(24'h07FFFF, "R4");
    send_word(24'h080000, 1'b0, 12); finish_word(24'hF80000, "R4");
    send_word(24'h0FFFFF, 1'b0, 0); finish_word(24'hFFFFFF, "R4");

    // R7 stopped bit clock after the word-clock fall
    send_word(24'h3C3C3C, 1'b1, 2);
    v = sample;
    repeat (80) @(negedge clk);
    check("R7", sample, v);
    finish_word(24'h3C3C3C, "R7");

    // random words, R2 / R3 / R4
    for (int k = 0; k < 24; k++) begin
      v  = W'($urandom);
      lw = 1'($urandom % 2);
      send_word(v, lw, int'($urandom % 9));
      finish_word(expect_word(v, lw), lw ? "R3" : "R4");
    end

    // R9 legal frames left no error
    check("R9", {23'd0, err}, '0);

    // R8 word clock rises with no bit-clock edge after its fall
    wck = 1'b1;
    for (int i = 0; i < 24; i++) bclk_cycle(1'b1);
    bck = 1'b0;
    repeat (2) @(negedge clk);
    wck = 1'b0;
    repeat (4) @(negedge clk);
    wck = 1'b1;
    repeat (8) @(negedge clk);
    check("R8", {23'd0, err}, 24'd1);
    wck = 1'b0;
    repeat (30) @(negedge clk);
    check("R8", {23'd0, err}, 24'd1);

    // R1 reset clears everything again
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1", sample, '0);
    check("R1", {22'd0, valid, err}, '0);
    rst = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule